// File: doc/BRIEF.md
# Down-Spread Fractional Divider Controller

This block steers the feedback divider of a fractional-N clock synthesizer so that the synthesized clock is slowly swept in frequency, which spreads its spectral energy and lowers peak emissions. Once per reference clock cycle it produces an integer divide modulus. Over time, the average of that modulus follows a programmable divide word minus a triangular offset.

Two pieces do the work. A sweep generator keeps an offset register that starts at zero and climbs by a programmable step each reference cycle until it reaches a programmed peak. It then falls by the same step back to zero, and the cycle repeats. The offset is taken away from the nominal integer-plus-fraction word, so the frequency only ever moves downward. A third-order cascade of three first-order accumulators turns the fractional part of the resulting word into a dithered integer. This pushes quantization error toward high frequencies, where the loop filter removes it.

The peak is normally set to 5000 ppm of the nominal word, for example 314573 for a word of 60.0 with a 20-bit fraction. The step sets the modulation rate. For a triangle frequency f_mod at reference frequency f_ref, the step is about 2·peak·f_mod/f_ref, and the full triangle period is 2·ceil(peak/step) reference cycles. A rate of 33 kHz is the intended default, and values from 30 to 33 kHz are obtained by the choice of step.

Top module: `ssc_divider_ctrl`

## Requirements
- R1: A synchronous reset clears the sweep offset, all three accumulators, the carry delay registers and the modulus output. The modulus reads 0 after reset, and the first sweep after reset moves downward from zero offset.
- R2: While spreadEn is low, the offset is held at zero and the sweep direction returns to downward. The modulator still dithers the static fraction, so the long-run mean modulus equals divInt + divFrac/2^20.
- R3: Down spread only: the offset never exceeds peakOffset, and the effective word never exceeds the nominal word {divInt, divFrac}.
- R4: On the falling ramp, the offset grows by stepSize each reference cycle. When offset + stepSize reaches or passes peakOffset, the offset is set to exactly peakOffset and the direction turns upward.
- R5: On the rising ramp, the offset shrinks by stepSize each reference cycle. When the offset is not larger than stepSize, it is set to exactly zero and the direction turns downward. Both ramps use the same step magnitude.
- R6: The triangle period is 2·ceil(peakOffset/stepSize) reference cycles, and the mean modulus over one period lies below the nominal word.
- R7: The modulus equals intPart + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here c1, c2 and c3 are the carries of the three accumulators in the current cycle, and primes mark the same carry one and two cycles earlier. Stage 1 adds the fraction, and each later stage adds the new sum of the stage before it. The modulus therefore stays within intPart −3 … intPart +4.
- R8: The effective word is {divInt, divFrac} − offset as a single 28-bit fixed-point subtraction. When the offset exceeds the fraction, the subtraction borrows from the integer part.
- R9: The modulus is registered. It changes only at a reference clock edge, and one new value is produced per cycle.
- R10: With a zero fraction and spreading disabled, the modulus is the constant divInt, with no dither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spreadEn | input | 1 | Enables the triangular sweep |
| divInt | input | 8 | Integer part of the nominal divide word |
| divFrac | input | 20 | Fractional part of the nominal divide word |
| stepSize | input | 20 | Offset change per reference cycle |
| peakOffset | input | 20 | Largest offset, normally 5000 ppm of the nominal word |
| modulus | output | 8 | Registered integer divide modulus for this cycle |

## Verification
Several input patterns are used, and each one separates a different kind of fault:
- A zero fraction with spreading off isolates the integer path, because any dither at all is a fault.
- A quarter fraction with spreading off exercises the cascade alone. Its long-run mean must land on the fraction.
- A realistic 5000 ppm sweep at a 33 kHz-class step reveals errors in slope, turning points and period length, through a per-cycle match against a behavioural model and a period-mean check.
- A peak that is not a multiple of the step tests the clamping at both ends.
- A fraction smaller than the offset forces the borrow into the integer part.
- Turning spreading off in the middle of a sweep shows whether the offset and direction are really released back to zero and downward.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Per-cycle command from the sweep control to the sweep datapath
  typedef struct packed {
    logic clear;   // force offset to zero
    logic down;    // falling-frequency ramp: offset grows
    logic up;      // rising-frequency ramp: offset shrinks
  } sweepCmd_t;
endpackage

// File: rtl/ssc_sweep_ctrl.sv
module ssc_sweep_ctrl
  import ssc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      spreadEn,
  input  logic      hitPeak,
  input  logic      hitZero,
  output sweepCmd_t cmd
);
  logic dirDown;

  always_comb begin
    cmd = '0;
    if (!spreadEn)     cmd.clear = 1'b1;
    else if (dirDown)  cmd.down  = 1'b1;
    else               cmd.up    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !spreadEn)          dirDown <= 1'b1;
    else if (dirDown && hitPeak)   dirDown <= 1'b0;
    else if (!dirDown && hitZero)  dirDown <= 1'b1;
  end

  // R4: reaching the peak on the falling ramp turns the sweep around
  p_turn_at_peak_r4: assert property (@(posedge clk) disable iff (rst)
    (spreadEn && dirDown && hitPeak) |=> !dirDown);
  // R5: reaching zero on the rising ramp turns the sweep around
  p_turn_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (spreadEn && !dirDown && hitZero) |=> dirDown);
  // R2: disabling spreading restores the downward direction
  p_dir_release_r2: assert property (@(posedge clk) disable iff (rst)
    !spreadEn |=> dirDown);
endmodule

// File: rtl/ssc_sweep_dp.sv
module ssc_sweep_dp
  import ssc_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  sweepCmd_t         cmd,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [FRAC_W-1:0] stepSize,
  input  logic [FRAC_W-1:0] peakOffset,
  output logic              hitPeak,
  output logic              hitZero,
  output logic [INT_W-1:0]  wordInt,
  output logic [FRAC_W-1:0] wordFrac
);
  localparam int WORD_W = INT_W + FRAC_W;

  logic [FRAC_W-1:0] offReg;
  logic [FRAC_W:0]   upSum;
  logic [WORD_W-1:0] nomWord, effWord;

  assign upSum   = {1'b0, offReg} + {1'b0, stepSize};
  assign hitPeak = (upSum >= {1'b0, peakOffset});
  assign hitZero = (offReg <= stepSize);

  always_ff @(posedge clk) begin
    if (rst || cmd.clear)  offReg <= '0;
    else if (cmd.down)     offReg <= hitPeak ? peakOffset : upSum[FRAC_W-1:0];
    else if (cmd.up)       offReg <= hitZero ? '0 : (offReg - stepSize);
  end

  // Borrow from the integer part falls out of the full-width subtraction
  assign nomWord  = {divInt, divFrac};
  assign effWord  = nomWord - {{INT_W{1'b0}}, offReg};
  assign wordInt  = effWord[WORD_W-1:FRAC_W];
  assign wordFrac = effWord[FRAC_W-1:0];

  // R3: the falling ramp never carries the offset past the peak
  p_peak_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.down |=> (offReg <= $past(peakOffset)));
  // R4: slope on the falling ramp away from the peak
  p_down_slope_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd.down && !hitPeak) |=> (offReg == $past(offReg) + $past(stepSize)));
  // R5: slope on the rising ramp away from zero
  p_up_slope_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd.up && !hitZero) |=> (offReg == $past(offReg) - $past(stepSize)));
  // R2: offset released to zero when spreading is off
  p_clear_offset_r2: assert property (@(posedge clk) disable iff (rst)
    cmd.clear |=> (offReg == '0));
  // R1: reset empties the offset
  p_reset_offset_r1: assert property (@(posedge clk)
    rst |=> (offReg == '0));
endmodule

// File: rtl/ssc_mash111.sv
module ssc_mash111 #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  wordInt,
  input  logic [FRAC_W-1:0] wordFrac,
  output logic [INT_W-1:0]  modulus
);
  localparam int ORDER = 3;
  localparam int EXT_W = INT_W + 2;

  logic [ORDER-1:0][FRAC_W-1:0] stageIn;
  logic [ORDER-1:0]             carry;
  logic                         c2Dly, c3Dly, c3Dly2;
  logic signed [3:0]            ySum;
  logic signed [EXT_W-1:0]      modNext;
  logic [INT_W-1:0]             modReg;

  assign stageIn[0] = wordFrac;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [FRAC_W-1:0] accR;
    logic [FRAC_W:0]   sum;
    assign sum      = {1'b0, accR} + {1'b0, stageIn[g]};
    assign carry[g] = sum[FRAC_W];
    if (g < ORDER - 1) begin : g_chain
      assign stageIn[g+1] = sum[FRAC_W-1:0];
    end
    always_ff @(posedge clk) begin
      if (rst) accR <= '0;
      else     accR <= sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2Dly  <= 1'b0;
      c3Dly  <= 1'b0;
      c3Dly2 <= 1'b0;
    end else begin
      c2Dly  <= carry[1];
      c3Dly  <= carry[2];
      c3Dly2 <= c3Dly;
    end
  end

  // c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
  assign ySum = $signed({3'b000, carry[0]})
              + $signed({3'b000, carry[1]}) - $signed({3'b000, c2Dly})
              + $signed({3'b000, carry[2]}) - $signed({2'b00, c3Dly, 1'b0})
              + $signed({3'b000, c3Dly2});

  assign modNext = $signed({2'b00, wordInt}) + EXT_W'(ySum);

  always_ff @(posedge clk) begin
    if (rst) modReg <= '0;
    else     modReg <= modNext[INT_W-1:0];
  end

  assign modulus = modReg;

  // R7: modulus stays within -3..+4 of the integer part it was built from
  p_mod_range_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((int'(modReg) - int'($past(wordInt)) >= -3) &&
              (int'(modReg) - int'($past(wordInt)) <= 4)));
  // R1: reset empties the output register
  p_reset_mod_r1: assert property (@(posedge clk)
    rst |=> (modReg == '0));
  // R10: a zero fraction produces no dither once the cascade has settled
  p_no_dither_r10: assert property (@(posedge clk) disable iff (rst)
    (wordFrac == '0 && $past(wordFrac) == '0 && $past(wordFrac, 2) == '0 &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3) &&
     g_stage[0].accR == '0 && g_stage[1].accR == '0 && g_stage[2].accR == '0 &&
     !c2Dly && !c3Dly && !c3Dly2) |=> (modReg == $past(wordInt)));
endmodule

// File: rtl/ssc_divider_ctrl.sv
module ssc_divider_ctrl
  import ssc_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spreadEn,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [FRAC_W-1:0] stepSize,
  input  logic [FRAC_W-1:0] peakOffset,
  output logic [INT_W-1:0]  modulus
);
  sweepCmd_t         cmd;
  logic              hitPeak, hitZero;
  logic [INT_W-1:0]  wordInt;
  logic [FRAC_W-1:0] wordFrac;

  ssc_sweep_ctrl i_ctrl (
    .clk(clk), .rst(rst), .spreadEn(spreadEn),
    .hitPeak(hitPeak), .hitZero(hitZero), .cmd(cmd)
  );

  ssc_sweep_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .divInt(divInt), .divFrac(divFrac),
    .stepSize(stepSize), .peakOffset(peakOffset),
    .hitPeak(hitPeak), .hitZero(hitZero),
    .wordInt(wordInt), .wordFrac(wordFrac)
  );

  ssc_mash111 #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_mash (
    .clk(clk), .rst(rst),
    .wordInt(wordInt), .wordFrac(wordFrac), .modulus(modulus)
  );
endmodule

// File: tb/test_ssc_divider_ctrl.sv
module test_ssc_divider_ctrl;
  localparam int     INT_W  = 8;
  localparam int     FRAC_W = 20;
  localparam longint ONE    = 64'd1 << FRAC_W;
  localparam longint MASK   = ONE - 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              spreadEn;
  logic [INT_W-1:0]  divInt;
  logic [FRAC_W-1:0] divFrac, stepSize, peakOffset;
  logic [INT_W-1:0]  modulus;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  longint mOff, a1, a2, a3, mMod, mIp, sumMod;
  bit     mDown;
  int     d2, d3, d3b;

  always #5 clk = ~clk;

  ssc_divider_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_ssc_divider_ctrl (
    .clk(clk), .rst(rst), .spreadEn(spreadEn), .divInt(divInt),
    .divFrac(divFrac), .stepSize(stepSize), .peakOffset(peakOffset),
    .modulus(modulus)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkTrue(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one reference cycle; compare against the model afterwards
  task automatic tick(string req);
    longint w, s;
    int c1, c2, c3;
    if (rst) begin
      mOff = 0; a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; d3b = 0;
      mDown = 1; mMod = 0; mIp = 0;
    end else begin
      w  = (longint'(divInt) * ONE) + longint'(divFrac) - mOff;  // R8 borrow
      mIp = w / ONE;
      s = a1 + (w % ONE); c1 = int'(s / ONE); a1 = s % ONE;
      s = a2 + a1;        c2 = int'(s / ONE); a2 = s % ONE;
      s = a3 + a2;        c3 = int'(s / ONE); a3 = s % ONE;
      mMod = mIp + c1 + c2 - d2 + c3 - 2 * d3 + d3b;
      d3b = d3; d3 = c3; d2 = c2;
      if (!spreadEn) begin
        mOff = 0; mDown = 1;
      end else if (mDown) begin
        if (mOff + stepSize >= peakOffset) begin mOff = peakOffset; mDown = 0; end
        else mOff = mOff + stepSize;
      end else begin
        if (mOff <= stepSize) begin mOff = 0; mDown = 1; end
        else mOff = mOff - stepSize;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, modulus, mMod);
    if (!rst)
      checkTrue({req, " R7 range"}, (modulus >= mIp - 3) && (modulus <= mIp + 4),
                modulus, mIp);
    sumMod += modulus;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    longint per, half;
    rst = 1; spreadEn = 0; divInt = 8'd60; divFrac = '0;
    stepSize = 20'd830; peakOffset = 20'd314573; sumMod = 0;
    mMod = 0; mIp = 0; mOff = 0; mDown = 1;
    @(negedge clk);
    tick("R1 reset"); tick("R1 reset");
    check("R1 reset modulus", modulus, 0);
    rst = 0;

    // R10: integer only, no dither
    for (int i = 0; i < 40; i++) begin
      tick("R10 static integer");
      check("R10 constant", modulus, 60);
    end

    // R2: spread off, static quarter fraction dithers to 60.25 on average
    divFrac = 20'h40000;
    for (int i = 0; i < 8; i++) tick("R2 settle");
    sumMod = 0;
    for (int i = 0; i < 400; i++) tick("R2 dither");
    checkTrue("R2 mean", (sumMod >= 24100 - 4) && (sumMod <= 24100 + 4), sumMod, 24100);

    // R4 R5 R6 R3: full 5000 ppm sweep, period 2*ceil(314573/830) = 760
    divFrac = '0;
    rst = 1; tick("R1 reset again"); rst = 0;
    spreadEn = 1;
    half = (314573 + 829) / 830;
    per = 2 * half;
    check("R6 period length", per, 760);
    sumMod = 0;
    for (int i = 0; i < 760; i++) tick("R4 R5 sweep");
    checkTrue("R3 R6 mean below nominal",
              (sumMod < 60 * 760) && (sumMod >= 60 * 760 - 160), sumMod, 60 * 760);
    for (int i = 0; i < 800; i++) tick("R6 second period");

    // R4 R5: peak not a multiple of the step, clamp at both ends
    rst = 1; tick("R1 reset"); rst = 0;
    peakOffset = 20'd1000; stepSize = 20'd300; divFrac = 20'h80000;
    for (int i = 0; i < 120; i++) tick("R4 R5 clamp");

    // R8: fraction smaller than the offset borrows from the integer part
    divFrac = 20'd100; peakOffset = 20'd314573; stepSize = 20'd20000;
    for (int i = 0; i < 200; i++) tick("R8 borrow");

    // R2: spreading turned off mid-sweep
    for (int i = 0; i < 7; i++) tick("R2 pre-disable");
    spreadEn = 0;
    for (int i = 0; i < 60; i++) tick("R2 disabled mid-sweep");
    spreadEn = 1;
    for (int i = 0; i < 40; i++) tick("R2 re-enable downward");

    // R3: zero peak keeps the word at nominal
    peakOffset = '0; divFrac = '0;
    for (int i = 0; i < 8; i++) tick("R3 zero peak settle");
    for (int i = 0; i < 30; i++) begin
      tick("R3 zero peak");
      checkTrue("R3 never above nominal", modulus <= 60 + 4, modulus, 60);
    end

    // R9: modulus only changes at clock edges
    @(posedge clk); #2;
    begin
      logic [INT_W-1:0] held;
      held = modulus;
      #2;
      check("R9 stable between edges", modulus, held);
    end
    @(negedge clk);
    summary();
  end
endmodule